// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block gathers interrupt requests from many peripherals and merges them onto a small set of CPU interrupt lines. Requests are arranged in groups of eight lines each. Every line has a sticky flag bit and an enable bit. Every group has an acknowledge latch. A group raises its CPU line only when the latch is clear, and raising the line sets the latch. That group then stays quiet until software writes 1 to the latch.

When the CPU takes a group's interrupt, it performs a vector fetch for that group. The block returns the index of the highest-priority line that is both flagged and enabled, and clears that flag. If no line qualifies, it returns the index of the group's first line. Software reaches the enables, the flags (read only) and the acknowledge latches through a simple synchronous register port.

Top module: `gie_top`

## Requirements
- R1: A high level on a line of `periph_req` (bit g*8+l is line l of group g) sets that line's flag. The flag stays set until a vector fetch clears it. Flags are read at register address {2'b00, g}, with line l in data bit l.
- R2: A flagged line whose enable bit is 0 never causes a pulse on `cpu_irq`.
- R3: While a group's acknowledge latch is 1, that group's `cpu_irq` bit stays 0, whatever its flags and enables are.
- R4: When the latch is 0 and some line is both flagged and enabled at a clock edge, `cpu_irq[g]` is high for exactly the following cycle, and the latch is set at that same edge.
- R5: Writing data bit g = 1 to the acknowledge address {2'b10, 4'h0} clears group g's latch. Writing 0 leaves it unchanged. A line that is still pending then raises `cpu_irq[g]` two edges after the write edge. A read of that address returns all the latches, with group g in bit g.
- R6: A vector fetch for group g returns g*8+l on `vec_index` one cycle later, where l is the lowest-numbered line that is both flagged and enabled. Line 0 has the highest priority. The fetch clears only that line's flag.
- R7: A vector fetch that finds no line both flagged and enabled returns g*8 and leaves every flag unchanged.
- R8: If a request and a fetch clear hit the same line at the same edge, the flag stays set.
- R9: After reset every flag, enable, latch and `cpu_irq` bit is 0. Writes to a flag address change nothing.
- R10: The enable register of group g, at address {2'b01, g}, is written and read back as written.
- R11: Groups are independent: one group's latch blocks neither the flags nor the interrupts of any other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | 96 | Peripheral request lines, bit g*8+l |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | [5:4] register kind, [3:0] group |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the address of the previous cycle |
| cpu_irq | output | 12 | One-cycle group interrupt pulses |
| vec_fetch | input | 1 | Vector fetch strobe |
| vec_group | input | 4 | Group being fetched |
| vec_index | output | 7 | Vector index from the last fetch |

## Verification
Flags, enables and latches change at the edge that samples the stimulus. Register read data appears one edge after the address is set. The interrupt pulse follows one edge after its cause becomes visible in state: two edges after a request, and two edges after an acknowledge write. The vector index and the flag clear appear one edge after the fetch strobe. The bench drives every input on the falling edge and samples on the next falling edge. Each of its checks names the exact falling edge on which a result is due. Where a check expects silence, it samples on every cycle of the window, so that a pulse arriving one cycle early or late is caught.

// File: rtl/gie_pkg.sv
package gie_pkg;
    localparam int GIE_LINES  = 8;
    localparam int GIE_GROUPS = 12;
    localparam int GIE_LW     = $clog2(GIE_LINES);

    typedef struct packed {
        logic [GIE_LINES-1:0] flag;
        logic [GIE_LINES-1:0] en;
        logic                 ack;
        logic                 irq;
    } grp_state_t;

    typedef enum logic [1:0] {
        KIND_FLAG = 2'd0,
        KIND_EN   = 2'd1,
        KIND_ACK  = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gie_ffs.sv
module gie_ffs #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        // scan downward so the lowest set bit is the last one written
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/gie_group.sv
module gie_group
    import gie_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GIE_LINES-1:0] req_i,
    input  logic                 en_we_i,
    input  logic [GIE_LINES-1:0] wdata_i,
    input  logic                 ack_clr_i,
    input  logic                 fetch_i,
    output logic [GIE_LINES-1:0] flag_o,
    output logic [GIE_LINES-1:0] en_o,
    output logic                 ack_o,
    output logic                 irq_o,
    output logic [GIE_LW-1:0]    line_o
);
    grp_state_t           st_q, st_d;
    logic                 hit;
    logic [GIE_LW-1:0]    win;
    logic [GIE_LINES-1:0] clr;
    logic                 fire;

    gie_ffs #(.N(GIE_LINES)) u_ffs (
        .vec_i (st_q.flag & st_q.en),
        .hit_o (hit),
        .idx_o (win)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (fetch_i && hit) clr[win] = 1'b1;
        st_d.flag = (st_q.flag & ~clr) | req_i;
        if (en_we_i) st_d.en = wdata_i;
        fire      = !st_q.ack && (|(st_q.flag & st_q.en));
        st_d.ack  = (st_q.ack & ~ack_clr_i) | fire;
        st_d.irq  = fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;
    assign ack_o  = st_q.ack;
    assign irq_o  = st_q.irq;
    assign line_o = win;

    // R4: a pulse is always accompanied by the latch
    a_r4_pulse_sets_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ack_o);
    // R3: a held latch silences the group on the next cycle
    a_r3_acked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !irq_o);
    // R2: a pulse needs a line that was flagged and enabled
    a_r2_pulse_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(st_q.flag & st_q.en)));
    // R1: flags never drop without a fetch
    a_r1_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_i |=> (($past(st_q.flag) & ~st_q.flag) == '0));
    // R6: a fetch drops at most one flag
    a_r6_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_i |=> ($countones($past(st_q.flag) & ~st_q.flag) <= 1));
endmodule

// File: rtl/gie_top.sv
module gie_top
    import gie_pkg::*;
#(
    parameter int NUM_GROUPS = GIE_GROUPS,
    parameter int DATA_W     = 16,
    parameter int GW         = $clog2(NUM_GROUPS),
    parameter int ADDR_W     = GW + 2,
    parameter int VEC_W      = $clog2(NUM_GROUPS * GIE_LINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GROUPS*GIE_LINES-1:0] periph_req,
    input  logic                            reg_we,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [DATA_W-1:0]               reg_rdata,
    output logic [NUM_GROUPS-1:0]           cpu_irq,
    input  logic                            vec_fetch,
    input  logic [GW-1:0]                   vec_group,
    output logic [VEC_W-1:0]                vec_index
);
    localparam int TOTAL = NUM_GROUPS * GIE_LINES;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [VEC_W-1:0]  vec;
    } top_state_t;

    top_state_t st_q, st_d;

    reg_kind_e                      kind;
    logic [GW-1:0]                  agrp;
    logic [NUM_GROUPS-1:0]          en_we, ack_clr, fetch_sel, ack_all;
    logic [GIE_LINES-1:0]           flag_a [NUM_GROUPS];
    logic [GIE_LINES-1:0]           en_a   [NUM_GROUPS];
    logic [GIE_LW-1:0]              line_a [NUM_GROUPS];

    assign kind = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
    assign agrp = reg_addr[GW-1:0];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign en_we[g]     = reg_we && (kind == KIND_EN) && (agrp == GW'(g));
        assign ack_clr[g]   = reg_we && (kind == KIND_ACK) && reg_wdata[g];
        assign fetch_sel[g] = vec_fetch && (vec_group == GW'(g));

        gie_group u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (periph_req[g*GIE_LINES +: GIE_LINES]),
            .en_we_i   (en_we[g]),
            .wdata_i   (reg_wdata[GIE_LINES-1:0]),
            .ack_clr_i (ack_clr[g]),
            .fetch_i   (fetch_sel[g]),
            .flag_o    (flag_a[g]),
            .en_o      (en_a[g]),
            .ack_o     (ack_all[g]),
            .irq_o     (cpu_irq[g]),
            .line_o    (line_a[g])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (agrp == GW'(g)) begin
                if (kind == KIND_FLAG) st_d.rdata = DATA_W'(flag_a[g]);
                if (kind == KIND_EN)   st_d.rdata = DATA_W'(en_a[g]);
            end
            if (vec_fetch && vec_group == GW'(g))
                st_d.vec = VEC_W'(g * GIE_LINES) + VEC_W'(line_a[g]);
        end
        if (kind == KIND_ACK) st_d.rdata = DATA_W'(ack_all);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign vec_index = st_q.vec;

    initial begin
        a_r5_width_fits: assert (NUM_GROUPS <= DATA_W && GIE_LINES <= DATA_W);
    end

    // R6: a fetch for a valid group yields an index inside that group
    a_r6_vec_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && (int'(vec_group) < NUM_GROUPS)) |=>
        ((int'(vec_index) / GIE_LINES) == int'($past(vec_group))));
    a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch |=> (int'(vec_index) < TOTAL));
endmodule

// File: tb/gie_top_bench.sv
`timescale 1ns/1ps
module gie_top_bench;
    localparam int NG = 12;
    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*NL-1:0] periph_req = '0;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [NG-1:0] cpu_irq;
    logic          vec_fetch = 1'b0;
    logic [3:0]    vec_group = '0;
    logic [6:0]    vec_index;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    gie_top u_gie_top (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .vec_fetch(vec_fetch),
        .vec_group(vec_group), .vec_index(vec_index)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] kind, input logic [3:0] g, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = {kind, g}; reg_wdata = d;
        cyc();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] kind, input logic [3:0] g, output logic [15:0] d);
        reg_addr = {kind, g};
        cyc();
        d = reg_rdata;
    endtask

    task automatic pulse_req(input int idx);
        periph_req[idx] = 1'b1;
        cyc();
        periph_req[idx] = 1'b0;
    endtask

    task automatic fetch(input logic [3:0] g, output logic [6:0] v);
        vec_fetch = 1'b1; vec_group = g;
        cyc();
        vec_fetch = 1'b0;
        v = vec_index;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R9 irq after reset", 32'(cpu_irq), 0);
        rd(2'd0, 4'd0, d); chk("R9 flag reset", 32'(d), 0);
        rd(2'd1, 4'd7, d); chk("R9 enable reset", 32'(d), 0);
        rd(2'd2, 4'd0, d); chk("R9 ack reset", 32'(d), 0);
    endtask

    task automatic t_enable_rw();
        logic [15:0] d;
        wr(2'd1, 4'd3, 16'h00A5);
        rd(2'd1, 4'd3, d); chk("R10 enable readback", 32'(d), 32'hA5);
        wr(2'd1, 4'd3, 16'h0000);
    endtask

    task automatic t_gate();
        logic [15:0] d;
        pulse_req(1*NL + 2);
        for (int i = 0; i < 4; i++) begin
            cyc(); chk("R2 disabled line silent", 32'(cpu_irq[1]), 0);
        end
        rd(2'd0, 4'd1, d); chk("R1 flag set and held", 32'(d), 32'h04);
    endtask

    task automatic t_forward();
        logic [15:0] d;
        wr(2'd1, 4'd1, 16'h0004);
        chk("R4 no pulse one edge after enable", 32'(cpu_irq[1]), 0);
        cyc(); chk("R4 pulse due", 32'(cpu_irq), 32'h002);
        cyc(); chk("R4 pulse lasts one cycle", 32'(cpu_irq[1]), 0);
        rd(2'd2, 4'd0, d); chk("R4 latch set", 32'(d), 32'h002);
    endtask

    task automatic t_block();
        logic [15:0] d;
        wr(2'd1, 4'd1, 16'h00FF);
        pulse_req(1*NL + 5);
        for (int i = 0; i < 4; i++) begin
            cyc(); chk("R3 latched group silent", 32'(cpu_irq[1]), 0);
        end
        wr(2'd2, 4'd0, 16'h0000);
        rd(2'd2, 4'd0, d); chk("R5 writing 0 keeps latch", 32'(d), 32'h002);
        chk("R5 no pulse after 0 write", 32'(cpu_irq[1]), 0);
        wr(2'd2, 4'd0, 16'h0002);
        chk("R5 no pulse one edge after clear", 32'(cpu_irq[1]), 0);
        cyc(); chk("R5 pending line forwarded", 32'(cpu_irq[1]), 1);
    endtask

    task automatic t_fetch();
        logic [6:0] v;
        logic [15:0] d;
        fetch(4'd1, v); chk("R6 lowest line wins", 32'(v), 10);
        rd(2'd0, 4'd1, d); chk("R6 only winner cleared", 32'(d), 32'h20);
        fetch(4'd1, v); chk("R6 next line wins", 32'(v), 13);
        rd(2'd0, 4'd1, d); chk("R6 flags empty", 32'(d), 0);
    endtask

    task automatic t_fallback();
        logic [6:0] v;
        logic [15:0] d;
        fetch(4'd1, v); chk("R7 empty group gives first line", 32'(v), 8);
        wr(2'd1, 4'd1, 16'h0000);
        periph_req[1*NL + 0] = 1'b1; periph_req[1*NL + 3] = 1'b1;
        cyc();
        periph_req = '0;
        fetch(4'd1, v); chk("R7 unenabled flags give first line", 32'(v), 8);
        rd(2'd0, 4'd1, d); chk("R7 flags untouched", 32'(d), 32'h09);
        wr(2'd0, 4'd1, 16'h0000);
        rd(2'd0, 4'd1, d); chk("R9 flag write ignored", 32'(d), 32'h09);
    endtask

    task automatic t_collide();
        logic [6:0] v;
        logic [15:0] d;
        wr(2'd1, 4'd2, 16'h0001);
        pulse_req(2*NL + 0);
        periph_req[2*NL + 0] = 1'b1;
        fetch(4'd2, v);
        periph_req = '0;
        chk("R8 fetch vector", 32'(v), 16);
        rd(2'd0, 4'd2, d); chk("R8 request wins over clear", 32'(d), 32'h01);
    endtask

    task automatic t_independent();
        logic [15:0] d;
        repeat (3) cyc();
        wr(2'd1, 4'd5, 16'h0080);
        pulse_req(5*NL + 7);
        cyc(); chk("R11 other group fires alone", 32'(cpu_irq), 32'h020);
        rd(2'd2, 4'd0, d); chk("R11 latch of group 5", 32'(d[5]), 1);
        chk("R11 group 1 latch kept", 32'(d[1]), 1);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_enable_rw();
        t_gate();
        t_forward();
        t_block();
        t_fetch();
        t_fallback();
        t_collide();
        t_independent();
        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=done", n);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule